// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor read and write a bank of byte-wide registers over a four-wire serial link. The host pulls the active-low select low and clocks in a direction flag, then a 7-bit address, then 8 data bits, all least significant bit first. On a write the slave collects the data byte and hands address and data to the register bank as a single-cycle strobe. On a read the slave fetches the addressed byte from the bank part-way through the frame and shifts it back to the host on the serial data output.

All serial inputs are brought into a fast internal clock through two-flop synchronisers, and serial clock edges are found by comparing successive synchronised samples. The end of the address field is seen in that internal domain, and the register fetch is issued a fixed few cycles later. A run-time configuration bit picks the serial clock edge that launches each read data bit. The output is given as a data value plus an enable, so the pad can float the line whenever the slave is not returning read data.

Top module: `sreg_slave`

## Requirements
- R1: After reset, `sdo_oe`, `reg_we` and `reg_re` are all low.
- R2: Bits are taken at rising serial clock edges in this order: direction flag (1 = read, 0 = write), address bits 0 to 6, then data bits 0 to 7; the byte a write presents on `reg_wdata`/`reg_addr` matches the bits sent.
- R3: A write frame with all 16 bits received and the select still low yields exactly one `reg_we` pulse, one internal clock wide.
- R4: Each read frame yields exactly one single-cycle `reg_re` pulse carrying the frame's address, no more than 6 internal clock cycles after the rising serial clock edge that carries address bit 6.
- R5: With `clke` = 0, read data bit k (k = 0..7) is launched on the (9+k)-th rising serial clock edge of the frame and the host can sample it at the following falling edge.
- R6: With `clke` = 1, read data bit 0 is launched on the falling edge right after address bit 6 and each further bit on the next falling edge; the host samples it at the next rising edge.
- R7: `sdo_oe` is high only during the data phase of a read frame; it stays low through the whole of every write frame and through the flag and address bits of a read, and falls within a few internal clock cycles after the select rises.
- R8: If the select rises before the 16th rising serial clock edge, no `reg_we` pulse is issued, the addressed register keeps its value, and the next frame decodes from its first bit.
- R9: Serial clock edges while the select is high are ignored; the serial clock may stay stopped between frames.
- R10: With a 40 ns internal clock, writes work at a 360 ns serial clock period, reads at 500 ns with `clke` = 0 and at 1 us with `clke` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csb | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| clke | input | 1 | Read launch edge select: 0 rising, 1 falling |
| sdo | output | 1 | Serial read data value |
| sdo_oe | output | 1 | Drive enable for the serial data pad |
| reg_addr | output | ADDR_W | Register bank address |
| reg_wdata | output | DATA_W | Register bank write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read fetch strobe |
| reg_rdata | input | DATA_W | Register bank read data, valid combinationally for `reg_addr` |

## Verification
The bench sweeps all 128 addresses with a write followed by a read, once with each launch edge, so a wrong bit order or an off-by-one address shift shows up as a mismatch at specific addresses, and a launch on the wrong edge returns bits shifted by one position. Frames cut short one bit before the end, and mid-address, target a slave that still strobes a partial byte into the bank or leaves its bit counter mid-frame, which would corrupt the register or misdecode the following frame. Read fetch latency is timed against the sixth internal cycle after address bit 6, catching a fetch that waits for another serial edge and so misses the first launch edge. Clock toggling with the select high targets a slave that counts edges outside a frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef struct packed {
    logic csb;
    logic sclk;
    logic sdi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{csb: 1'b1, sclk: 1'b0, sdi: 1'b0};

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              is_read
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] ADDR_END_C = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] LAST_C     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_C     = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              fetched_q, fetched_d;
  logic              wr_pend_q, wr_pend_d;
  logic              we_q, we_d;
  logic              re_q, re_d;

  always_comb begin
    cnt_d     = cnt_q;
    rw_d      = rw_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    fetched_d = fetched_q;
    wr_pend_d = 1'b0;
    re_d      = 1'b0;
    if (csb_s) begin
      cnt_d     = '0;
      rw_d      = 1'b0;
      fetched_d = 1'b0;
    end else begin
      if (sclk_rise && (cnt_q != FULL_C)) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == '0)            rw_d    = sdi_s;
        else if (cnt_q < ADDR_END_C) addr_d  = {sdi_s, addr_q[ADDR_W-1:1]};
        else                        wdata_d = {sdi_s, wdata_q[DATA_W-1:1]};
        if ((cnt_q == LAST_C) && !rw_q) wr_pend_d = 1'b1;
      end
      if ((cnt_q == ADDR_END_C) && rw_q && !fetched_q) begin
        re_d      = 1'b1;
        fetched_d = 1'b1;
      end
    end
    we_d = wr_pend_q && !csb_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      fetched_q <= 1'b0;
      wr_pend_q <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rw_q      <= rw_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      fetched_q <= fetched_d;
      wr_pend_q <= wr_pend_d;
      we_q      <= we_d;
      re_q      <= re_d;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign is_read   = rw_q;

  // Cycles spent with the address field complete (checker support).
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age_q <= '0;
    else if (cnt_q != ADDR_END_C) age_q <= '0;
    else if (age_q != 2'd3)      age_q <= age_q + 2'd1;
  end

  // R3: strobe only once a whole write frame is held
  p_we_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ((cnt_q == FULL_C) && !rw_q));

  // R3: strobe lasts one cycle
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R4: fetch started within three cycles of address completion
  p_fetch_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == ADDR_END_C) && rw_q && (age_q == 2'd3)) |-> fetched_q);

  // R4: fetch strobe lasts one cycle
  p_re_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R9: no edges counted while deselected
  p_idle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> (cnt_q == '0));

endmodule

// File: rtl/sreg_sdo.sv
module sreg_sdo #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              clke,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int LEFT_W = $clog2(DATA_W + 1);
  localparam logic [LEFT_W-1:0] LOAD_C = LEFT_W'(DATA_W);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic              launch;

  assign launch = clke ? sclk_fall : sclk_rise;

  always_comb begin
    shreg_d = shreg_q;
    left_d  = left_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    if (csb_s) begin
      left_d = '0;
      oe_d   = 1'b0;
    end else if (load) begin
      shreg_d = load_data;
      left_d  = LOAD_C;
    end else if (launch && (left_q != '0)) begin
      sdo_d   = shreg_q[0];
      shreg_d = shreg_q >> 1;
      left_d  = left_q - 1'b1;
      oe_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  // R5 (and R6): a driven bit changes only after the selected launch edge
  p_sdo_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $past(launch));

  // R6 (and R5): driving starts only at a launch edge
  p_oe_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(launch));

  // R7: deselect releases the line
  p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> !sdo_oe);

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              clke,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);

  import sreg_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  pins_t pins_raw, pins_s;
  assign pins_raw = '{csb: csb, sclk: sclk, sdi: sdi};

  sreg_sync #(
    .WIDTH  ($bits(pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d    (pins_raw),
    .q    (pins_s)
  );

  logic sclk_prev_q;
  logic sclk_rise, sclk_fall;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sclk_prev_q <= 1'b0;
    else            sclk_prev_q <= pins_s.sclk;
  end
  assign sclk_rise =  pins_s.sclk && !sclk_prev_q;
  assign sclk_fall = !pins_s.sclk &&  sclk_prev_q;

  logic is_read;

  sreg_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .csb_s    (pins_s.csb),
    .sdi_s    (pins_s.sdi),
    .sclk_rise(sclk_rise),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .is_read  (is_read)
  );

  sreg_sdo #(
    .DATA_W(DATA_W)
  ) u_sdo (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .csb_s    (pins_s.csb),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .clke     (clke),
    .load     (reg_re),
    .load_data(reg_rdata),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  // R7: the line is driven only inside a read frame
  p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    sdo_oe |-> is_read);

  // R1: strobes and drive stay off while reset is held internally
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_int |-> (!sdo_oe && !reg_we && !reg_re));

  // R3 / R4: read fetch and write strobe never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(reg_we && reg_re));

endmodule

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb;

  localparam int CLK_P   = 40;
  localparam int HALF_WR = 180;
  localparam int HALF_R0 = 250;
  localparam int HALF_R1 = 500;
  localparam int GAP     = 200;
  localparam int NADDR   = 128;

  logic       clk, rst_n, csb, sclk, sdi, clke;
  logic       sdo, sdo_oe, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  sreg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdi(sdi), .clke(clke),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // register bank model
  logic [7:0] mem [NADDR];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NADDR; a++) mem[a] <= 8'(a) ^ 8'hA5;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  initial begin
    clk = 1'b0;
    #7;
    forever #(CLK_P/2) clk = ~clk;
  end

  int   n_tests = 0, n_fail = 0;
  bit   done = 0;
  int   we_cnt = 0, re_cnt = 0, oe_wr_bad = 0;
  logic [6:0] we_addr, re_addr;
  logic [7:0] we_data;
  time  re_time, t_a6;
  bit   wr_active = 0;

  always @(negedge clk) begin
    if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
    if (reg_re) begin re_cnt++; re_addr = reg_addr; re_time = $time; end
    if (sdo_oe && wr_active) oe_wr_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input int half,
                      output logic [7:0] got, output bit oe_early, output bit oe_miss);
    logic [15:0] bits;
    bits = {d, a, rd};
    got = '0; oe_early = 0; oe_miss = 0;
    wr_active = !rd;
    csb = 1'b0;
    #(half);
    for (int i = 0; i < nbits; i++) begin
      sdi = (rd && i >= 8) ? 1'b0 : bits[i];
      #(half);
      if (rd && i < 8 && sdo_oe) oe_early = 1;
      if (rd && clke && i >= 8) begin got[i-8] = sdo; if (!sdo_oe) oe_miss = 1; end
      sclk = 1'b1;
      if (i == 7) t_a6 = $time;
      #(half);
      if (rd && !clke && i >= 8) begin got[i-8] = sdo; if (!sdo_oe) oe_miss = 1; end
      sclk = 1'b0;
    end
    #(half);
    csb = 1'b1;
    #(GAP);
    wr_active = 0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string tag);
    logic [7:0] g; bit e, m; int w0;
    w0 = we_cnt;
    xfer(1'b0, a, d, 16, HALF_WR, g, e, m);
    chk(we_cnt == w0 + 1, {tag, " R3 one strobe"}, we_cnt - w0, 1);
    chk(we_addr == a && we_data == d, {tag, " R2 write fields"}, {we_addr, we_data}, {a, d});
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input int half, input string tag);
    logic [7:0] g; bit e, m; int r0;
    r0 = re_cnt;
    xfer(1'b1, a, 8'h00, 16, half, g, e, m);
    chk(g == exp, clke ? {tag, " R6 read data"} : {tag, " R5 read data"}, g, exp);
    chk(!e && !m, {tag, " R7 drive window"}, {e, m}, 0);
    chk(re_cnt == r0 + 1 && re_addr == a, {tag, " R4 fetch addr"}, re_addr, a);
    chk(re_time > t_a6 && (re_time - t_a6) <= 6 * CLK_P, {tag, " R4 fetch latency"},
        int'(re_time - t_a6), 6 * CLK_P);
  endtask

  initial begin
    logic [7:0] g; bit e, m; int w0;
    csb = 1'b1; sclk = 1'b0; sdi = 1'b0; clke = 1'b0; rst_n = 1'b0;
    #200;
    // R1: reset state
    chk(!sdo_oe && !reg_we && !reg_re, "R1 reset outputs", {sdo_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    #200;
    chk(!sdo_oe && !reg_we && !reg_re, "R1 after release", {sdo_oe, reg_we, reg_re}, 0);

    // R9: clocking while deselected is ignored
    w0 = we_cnt;
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin #(HALF_WR) sclk = 1'b1; #(HALF_WR) sclk = 1'b0; end
    #(GAP);
    chk(we_cnt == w0 && re_cnt == 0 && !sdo_oe, "R9 idle clocking", we_cnt - w0, 0);
    do_read(7'h33, 8'h33 ^ 8'hA5, HALF_R0, "idle-then");

    // R8: aborted writes leave the register untouched
    w0 = we_cnt;
    xfer(1'b0, 7'h15, 8'h3C, 12, HALF_WR, g, e, m);
    chk(we_cnt == w0, "R8 abort mid-data no strobe", we_cnt - w0, 0);
    xfer(1'b0, 7'h15, 8'h3C, 15, HALF_WR, g, e, m);
    chk(we_cnt == w0, "R8 abort one bit short", we_cnt - w0, 0);
    xfer(1'b0, 7'h15, 8'h3C, 4, HALF_WR, g, e, m);
    chk(we_cnt == w0, "R8 abort in address", we_cnt - w0, 0);
    do_read(7'h15, 8'h15 ^ 8'hA5, HALF_R0, "R8 after abort");
    xfer(1'b1, 7'h16, 8'h00, 11, HALF_R0, g, e, m);
    #(4 * CLK_P);
    chk(!sdo_oe, "R7 released after aborted read", sdo_oe, 0);

    // R10: full sweep, rising launch edge
    clke = 1'b0;
    for (int a = 0; a < NADDR; a++) begin
      do_write(7'(a), 8'(a * 3 + 8'h5A), "R10 sweep0");
      do_read(7'(a), 8'(a * 3 + 8'h5A), HALF_R0, "R10 sweep0");
    end
    // R10: full sweep, falling launch edge
    clke = 1'b1;
    for (int a = 0; a < NADDR; a++) begin
      do_write(7'(a), 8'(~(a ^ 8'hC3)), "R10 sweep1");
      do_read(7'(a), 8'(~(a ^ 8'hC3)), HALF_R1, "R10 sweep1");
    end
    chk(oe_wr_bad == 0, "R7 no drive during writes", oe_wr_bad, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule